// File: doc/BRIEF.md
# Priority-Channel Repeat Sweep Sequencer

This block sequences a multi-channel analog-to-digital converter in a repeating sweep in which channel 0 is favoured. Once a run begins, channel 0 is converted first. After every channel 0 conversion, exactly one other channel of the selected group is converted, and then control returns to channel 0. With four channels the order is 0,1,0,2,0,3,0,1,... The sweep repeats until the start flag is cleared. The conversion-complete interrupt is never raised in this mode.

The converter is modelled as a fixed-latency unit. The sequencer times each conversion itself, in converter-clock ticks derived from the source clock. It samples the converter's result word at the end of the conversion and copies it into the result register of the channel just converted. A one-cycle strobe carrying the channel index marks each update.

A run can be launched by the software flag alone, or by the software flag followed by an external trigger. Resolution, channel group, clock division and trigger source are captured only when the flag rises.

Top module: `prio_sweep_seq`

## Requirements
- R1: The first conversion after a launch is always on channel 0 (`conv_ch` = 0 while `conv_start` pulses).
- R2: A finished conversion on channel i writes its result into result register i, which is exposed as `res_all[i*10 +: 10]`.
- R3: After each channel 0 conversion, exactly one other selected channel is converted, and then channel 0 is converted again. The other channels are taken in rising index order and wrap back to channel 1.
- R4: `grp_sel` picks the channel group: 0 selects channel 0 only (converted repeatedly), 1 selects channels 0–1, 2 selects channels 0–2, and 3 selects channels 0–3.
- R5: Clearing `start_flag` lets the conversion in progress finish and commit its result. No further conversion is issued, and `conv_busy` falls on that completion.
- R6: `irq` stays 0 at all times.
- R7: One conversion lasts 28 converter-clock ticks when `res_10b` = 0 (8-bit) and 33 ticks when `res_10b` = 1 (10-bit). Back-to-back conversions follow with no gap.
- R8: The converter clock is the source clock divided by 4 (`div_sel` = 0), by 2 (`div_sel` = 1), or by 1 (`div_sel` = 2 or 3).
- R9: With `trig_src` = 0, the rise of `start_flag` launches the run. With `trig_src` = 1, the rise only arms the block, and the run launches on the first cycle in which `ext_trig` is 1 while `start_flag` is still 1. Clearing `start_flag` while armed disarms the block.
- R10: `grp_sel`, `res_10b`, `div_sel` and `trig_src` are captured only on the rise of `start_flag` from idle. Changing them during a run has no effect on that run.
- R11: Each new launch resumes the non-zero channel order at channel 1.
- R12: Each commit pulses `res_valid` for one cycle, with `res_ch` giving the channel and `res_data` giving the value. In 8-bit mode the value is `conv_data[7:0]` with bits 9:8 forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_flag | input | 1 | Software run flag |
| trig_src | input | 1 | 0: software launch, 1: external trigger launch |
| ext_trig | input | 1 | External trigger level |
| res_10b | input | 1 | 1: 10-bit, 0: 8-bit resolution |
| grp_sel | input | 2 | Channel group select |
| div_sel | input | 2 | Converter clock divider select |
| conv_data | input | 10 | Result word from the converter |
| conv_start | output | 1 | One-cycle pulse launching a conversion |
| conv_busy | output | 1 | A conversion is in progress |
| conv_ch | output | 2 | Channel being converted |
| res_valid | output | 1 | Result register update strobe |
| res_ch | output | 2 | Channel of the update |
| res_data | output | 10 | Value written |
| res_all | output | 40 | All four result registers, channel i at bits i*10+9:i*10 |
| irq | output | 1 | Conversion-complete interrupt, never raised |

## Verification
The commit of a finished conversion and the launch of the next one fall on the same clock edge, because the next `conv_start` pulses together with `res_valid`. Every uninterrupted run provokes this, and divide-by-1 does so at the tightest spacing. The bench judges it by requiring exactly 28 or 33 times the division between strobes, the correct channel in the strobe, and the correct channel in the following launch. A clear of `start_flag` that lands during a conversion is the second collision. It is judged by requiring one more commit and then silence with `conv_busy` low.

// File: rtl/prio_sweep_seq.sv
module prio_sweep_seq #(
  parameter int CH_W   = 2,
  parameter int D_W    = 10,
  parameter int LAT_LO = 28,
  parameter int LAT_HI = 33
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_flag,
  input  logic                      trig_src,
  input  logic                      ext_trig,
  input  logic                      res_10b,
  input  logic [CH_W-1:0]           grp_sel,
  input  logic [1:0]                div_sel,
  input  logic [D_W-1:0]            conv_data,
  output logic                      conv_start,
  output logic                      conv_busy,
  output logic [CH_W-1:0]           conv_ch,
  output logic                      res_valid,
  output logic [CH_W-1:0]           res_ch,
  output logic [D_W-1:0]            res_data,
  output logic [(1<<CH_W)*D_W-1:0]  res_all,
  output logic                      irq
);
  localparam int NCH = 1 << CH_W;
  localparam int CW  = $clog2(LAT_HI + 1);

  logic go_q, armed, res10_q;
  logic [CH_W-1:0] grp_q, oth;
  logic [1:0] div_q, pc;
  logic [CW-1:0] cnt;
  logic [D_W-1:0] rr [NCH];

  wire idle   = ~conv_busy & ~armed;
  wire rise   = start_flag & ~go_q;
  wire launch = (idle & rise & ~trig_src) | (armed & start_flag & ext_trig);
  wire [1:0] pmax = (div_q == 2'd0) ? 2'd3 : (div_q == 2'd1) ? 2'd1 : 2'd0;
  wire tick   = conv_busy & (pc == pmax);
  wire [CW-1:0] lat_m1 = res10_q ? CW'(LAT_HI - 1) : CW'(LAT_LO - 1);
  wire done   = tick & (cnt == lat_m1);
  wire to_oth = (conv_ch == '0) & (grp_q != '0);
  wire [CH_W-1:0] nxt    = to_oth ? oth : '0;
  wire [CH_W-1:0] oth_nx = (oth == grp_q) ? CH_W'(1) : oth + CH_W'(1);
  wire [D_W-1:0] res_w = res10_q ? conv_data : {{(D_W-8){1'b0}}, conv_data[7:0]};

  assign irq = 1'b0;

  for (genvar i = 0; i < NCH; i++) begin : g_out
    assign res_all[i*D_W +: D_W] = rr[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go_q <= 1'b0; armed <= 1'b0; res10_q <= 1'b0;
      grp_q <= '0; oth <= CH_W'(1); div_q <= '0; pc <= '0; cnt <= '0;
      conv_start <= 1'b0; conv_busy <= 1'b0; conv_ch <= '0;
      res_valid <= 1'b0; res_ch <= '0; res_data <= '0;
      for (int i = 0; i < NCH; i++) rr[i] <= '0;
    end else begin
      go_q       <= start_flag;
      conv_start <= 1'b0;
      res_valid  <= 1'b0;
      if (idle & rise) begin
        grp_q <= grp_sel; res10_q <= res_10b; div_q <= div_sel;
        oth <= CH_W'(1); armed <= trig_src;
      end
      if (armed & ~start_flag) armed <= 1'b0;
      if (launch) begin
        conv_busy <= 1'b1; armed <= 1'b0; conv_ch <= '0;
        cnt <= '0; pc <= '0; conv_start <= 1'b1;
      end else if (conv_busy) begin
        pc <= tick ? 2'd0 : pc + 2'd1;
        if (tick) cnt <= cnt + CW'(1);
        if (done) begin
          res_valid <= 1'b1; res_ch <= conv_ch; res_data <= res_w;
          rr[conv_ch] <= res_w;
          cnt <= '0;
          if (start_flag) begin
            conv_ch <= nxt; conv_start <= 1'b1;
            if (to_oth) oth <= oth_nx;
          end else begin
            conv_busy <= 1'b0;
          end
        end
      end
    end
  end

  a_r1_first_ch0: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start && !$past(conv_busy) |-> conv_ch == '0);
  a_r3_back_to_ch0: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start && $past(conv_busy) && $past(conv_ch) != '0 |-> conv_ch == '0);
  a_r4_in_group: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> conv_ch <= grp_q);
  a_r5_stop_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !$past(start_flag) |-> !conv_busy && !conv_start);
  a_r12_strobe_ch: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_ch == $past(conv_ch));
  a_r12_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res10_q |-> res_data[D_W-1:8] == '0);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
endmodule

// File: tb/prio_sweep_seq_tb.sv
module prio_sweep_seq_tb;
  logic clk = 0, rst_n = 0;
  logic start_flag = 0, trig_src = 0, ext_trig = 0, res_10b = 0;
  logic [1:0] grp_sel = 0, div_sel = 0;
  logic [9:0] conv_data, base = 10'h2A0;
  logic conv_start, conv_busy, res_valid, irq;
  logic [1:0] conv_ch, res_ch;
  logic [9:0] res_data;
  logic [39:0] res_all;
  int nchk = 0, nerr = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  prio_sweep_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_flag(start_flag), .trig_src(trig_src),
    .ext_trig(ext_trig), .res_10b(res_10b), .grp_sel(grp_sel), .div_sel(div_sel),
    .conv_data(conv_data), .conv_start(conv_start), .conv_busy(conv_busy),
    .conv_ch(conv_ch), .res_valid(res_valid), .res_ch(res_ch), .res_data(res_data),
    .res_all(res_all), .irq(irq));

  assign conv_data = base + 10'(conv_ch) * 10'd37;

  // {trig_src, grp_sel[1:0], res_10b, div_sel[1:0]}
  localparam logic [5:0] VEC [0:5] = '{
    6'b0_11_1_10, 6'b0_01_0_00, 6'b0_00_1_01,
    6'b0_10_0_10, 6'b1_11_1_10, 6'b0_11_0_01 };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_ch(input int g, input int k);
    if (g == 0 || k % 2 == 0) return 0;
    return 1 + ((k - 1) / 2) % g;
  endfunction

  function automatic logic [9:0] exp_val(input logic [9:0] b, input int ch, input bit r10);
    logic [9:0] v = b + 10'(ch) * 10'd37;
    return r10 ? v : {2'b00, v[7:0]};
  endfunction

  task automatic wait_strobe(output int cyc);
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!res_valid && cyc < 5000);
  endtask

  task automatic run(input bit tr, input int g, input bit r10, input int dv, input int nres);
    int cyc, per, ch;
    per = (r10 ? 33 : 28) * (dv == 0 ? 4 : dv == 1 ? 2 : 1);
    @(negedge clk);
    trig_src = tr; grp_sel = 2'(g); res_10b = r10; div_sel = 2'(dv);
    start_flag = 1;
    if (tr) begin
      repeat (3) @(negedge clk);
      check(!conv_busy, "R9", "busy before trigger", conv_busy, 0);
      ext_trig = 1;
    end
    for (int k = 0; k < nres; k++) begin
      wait_strobe(cyc);
      ch = exp_ch(g, k);
      check(res_ch == 2'(ch), k == 0 ? "R1" : "R3/R4", "channel", res_ch, ch);
      check(res_data == exp_val(base, ch, r10), "R2/R12", "data", res_data, exp_val(base, ch, r10));
      check(res_all[ch*10 +: 10] == exp_val(base, ch, r10), "R2", "result reg", res_all[ch*10 +: 10], exp_val(base, ch, r10));
      check(cyc == (k == 0 ? per + 1 : per), "R7/R8", "spacing", cyc, k == 0 ? per + 1 : per);
      check(irq == 0, "R6", "irq", irq, 0);
      if (k == nres - 2) start_flag = 0;
    end
    ext_trig = 0;
    for (int c = 0; c < 2 * per; c++) begin
      @(negedge clk);
      if (res_valid || conv_busy) begin
        check(0, "R5", "activity after stop", 1, 0);
        break;
      end
    end
    check(!conv_busy, "R5", "busy after stop", conv_busy, 0);
  endtask

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    check(conv_busy == 0 && res_valid == 0 && conv_start == 0, "R5", "reset idle", conv_busy, 0);
    check(res_all == 0, "R2", "reset results", int'(res_all[31:0]), 0);
    check(irq == 0, "R6", "reset irq", irq, 0);
    rst_n = 1;
    for (int v = 0; v < 6; v++) begin
      base = 10'h2A0 + 10'(v * 19);
      run(VEC[v][5], int'(VEC[v][4:3]), VEC[v][2], int'(VEC[v][1:0]), 8);
    end
    // R11: stop after 0,1,0 then restart must resume at channel 1
    base = 10'h155;
    run(0, 3, 1, 2, 3);
    run(0, 3, 1, 2, 4);
    // R10: mode inputs changed during a run are ignored
    base = 10'h3F3;
    @(negedge clk);
    trig_src = 0; grp_sel = 3; res_10b = 1; div_sel = 2; start_flag = 1;
    @(negedge clk);
    grp_sel = 0; res_10b = 0; div_sel = 0; trig_src = 1;
    for (int k = 0; k < 4; k++) begin
      wait_strobe(cyc);
      check(res_ch == 2'(exp_ch(3, k)), "R10", "channel after change", res_ch, exp_ch(3, k));
      check(res_data == exp_val(base, exp_ch(3, k), 1), "R10", "width after change", res_data, exp_val(base, exp_ch(3, k), 1));
      check(cyc == (k == 0 ? 33 : 33), "R10", "spacing after change", cyc, 33);
      if (k == 2) start_flag = 0;
    end
    repeat (80) @(negedge clk);
    check(!conv_busy, "R5", "stopped", conv_busy, 0);
    // R9: clearing the flag while armed disarms
    @(negedge clk);
    trig_src = 1; start_flag = 1;
    repeat (3) @(negedge clk);
    start_flag = 0;
    repeat (2) @(negedge clk);
    ext_trig = 1;
    repeat (5) @(negedge clk);
    check(!conv_busy && !res_valid, "R9", "disarmed trigger", conv_busy, 0);
    ext_trig = 0;
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule